// File: doc/BRIEF.md
# Receive Clock-Source Supervisor with Transition-Density Monitor

This block decides, for one receive channel, whether the clock-recovery loop should follow the incoming serial bit stream or fall back to the local reference clock. It runs on the bit clock and watches the recovered bits for long runs with no transitions. It also takes two analog status flags: one says the signal level is adequate, the other says the frequency is within range. Both flags are resynchronised before use.

A detection-enable input picks how strict the decision is. When it is high, the level flag, the range flag and the density monitor must all be good. When it is low, only the range flag counts. A use-data input works as an override: when it is low, the loop is forced onto the reference. The block produces a lock-to-data select and an active-low link-fault indication. The select is raised only after the required checks have stayed good for a full qualification window. It is dropped on the first cycle after any required check fails.

Top module: `cdr_src_sup`

## Requirements
- R1: After an asynchronous active-low reset, `lock_data` is 0 and `link_fault_n` is 0.
- R2: With `det_en` high, a run of 60 bit-clock cycles with no change of `ser_bit` is a density violation, and `lock_data` falls. A run of fewer than 45 identical bits leaves `lock_data` high.
- R3: The density violation clears on the first change of `ser_bit`. `lock_data` then re-qualifies through the R8 window.
- R4: With `det_en` high, `lvl_ok` low makes `lock_data` fall within a few cycles (synchroniser plus one register).
- R5: `rng_ok` low makes `lock_data` fall within a few cycles, whatever the value of `det_en`.
- R6: With `det_en` low, `lvl_ok` and the density monitor are ignored. `lock_data` stays high through `lvl_ok` low and through runs longer than 60 identical bits.
- R7: `use_data` low forces `lock_data` and `link_fault_n` to 0 in the same cycle, whatever the checks say.
- R8: `lock_data` rises only after all required checks have been good for 60 consecutive bit-clock cycles. Any failure restarts the count.
- R9: `link_fault_n` is 1 exactly while `lock_data` is 1 (a low level means a link fault).
- R10: `lvl_ok` and `rng_ok` pass through a two-flop synchroniser before they are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Recovered serial bit, one per clock |
| lvl_ok | input | 1 | Signal-level status, 1 = within limits (asynchronous) |
| rng_ok | input | 1 | Frequency-range status, 1 = within limits (asynchronous) |
| det_en | input | 1 | 1 = level, range and density all required; 0 = range only |
| use_data | input | 1 | 0 = force the loop to the reference clock |
| lock_data | output | 1 | 1 = loop tracks incoming data, 0 = tracks reference |
| link_fault_n | output | 1 | Link-fault indication, active low |

## Verification
The bench holds the serial bit for runs on both sides of the 60-bit limit. A design that counts the run wrongly would either drop the lock early or hold it through a dead line. The bench checks that the lock stays low well into the qualification window and high after it. An early qualify, or one that never restarts, shows up there. It also shows up in the re-lock after a density fault clears. The bench confirms that the level flag and long runs are ignored when detection is disabled, and that the use-data override and the fault output act at once. A design that only registered the override, or left the fault output high while forced local, would be caught.

// File: rtl/cdr_src_sup.sv
module cdr_src_sup #(
  parameter int RUN_LIMIT = 60,
  parameter int QUAL_LEN  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_bit,
  input  logic lvl_ok,
  input  logic rng_ok,
  input  logic det_en,
  input  logic use_data,
  output logic lock_data,
  output logic link_fault_n
);
  localparam int RW = $clog2(RUN_LIMIT + 1);
  localparam int QW = $clog2(QUAL_LEN + 1);

  logic [1:0]    lvl_sy, rng_sy;
  logic          lvl_s, rng_s;
  logic          prev_bit;
  logic [RW-1:0] run_cnt;
  logic          dens_bad;
  logic          checks_ok;
  logic [QW-1:0] qual_cnt;
  logic          lock_q;

  // R10: two-flop synchronisers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_sy <= '0;
      rng_sy <= '0;
    end else begin
      lvl_sy <= {lvl_sy[0], lvl_ok};
      rng_sy <= {rng_sy[0], rng_ok};
    end

  assign lvl_s = lvl_sy[1];
  assign rng_s = rng_sy[1];

  // run-length counter, saturating at RUN_LIMIT
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_bit <= 1'b0;
      run_cnt  <= '0;
    end else begin
      prev_bit <= ser_bit;
      if (ser_bit != prev_bit)
        run_cnt <= '0;
      else if (run_cnt != RW'(RUN_LIMIT))
        run_cnt <= run_cnt + 1'b1;
    end

  assign dens_bad  = (run_cnt == RW'(RUN_LIMIT));
  assign checks_ok = det_en ? (lvl_s & rng_s & ~dens_bad) : rng_s;

  // qualification window and lock register
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      qual_cnt <= '0;
      lock_q   <= 1'b0;
    end else if (!use_data || !checks_ok) begin
      qual_cnt <= '0;
      lock_q   <= 1'b0;
    end else if (!lock_q) begin
      if (qual_cnt == QW'(QUAL_LEN - 1))
        lock_q <= 1'b1;
      else
        qual_cnt <= qual_cnt + 1'b1;
    end

  assign lock_data    = lock_q & use_data;
  assign link_fault_n = lock_data;

  // R2
  dens_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && dens_bad) |=> !lock_q);
  // R3
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_bit != prev_bit) |=> (run_cnt == '0));
  // R4
  lvl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && !lvl_s) |=> !lock_q);
  // R5
  rng_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rng_s |=> !lock_q);
  // R7
  force_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !use_data |=> !lock_q);
  // R8
  qual_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(qual_cnt == QW'(QUAL_LEN - 1)));
  // R9
  fault_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fault_n |-> (lock_q && use_data));
endmodule

// File: tb/cdr_src_sup_tb.sv
module cdr_src_sup_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_bit = 1'b0, lvl_ok = 1'b0, rng_ok = 1'b0, det_en = 1'b1, use_data = 1'b1;
  logic hold = 1'b0;
  logic lock_data, link_fault_n;
  int checks = 0, errors = 0;

  cdr_src_sup u_dut (.clk, .rst_n, .ser_bit, .lvl_ok, .rng_ok, .det_en, .use_data,
                     .lock_data, .link_fault_n);

  always #10 clk = ~clk;
  always @(negedge clk) if (!hold) ser_bit <= ~ser_bit;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    #5; chk("R1 lock", lock_data, 1'b0); chk("R1 fault", link_fault_n, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_qualify;
    lvl_ok = 1'b1; rng_ok = 1'b1;
    cyc(40); chk("R8 early", lock_data, 1'b0);
    cyc(35); chk("R8 locked", lock_data, 1'b1);
    chk("R9 high", link_fault_n, 1'b1);
  endtask

  task automatic t_density;
    hold = 1'b1;
    cyc(45); chk("R2 short run", lock_data, 1'b1);
    cyc(25); chk("R2 long run", lock_data, 1'b0);
    chk("R9 low", link_fault_n, 1'b0);
    hold = 1'b0;
    cyc(5);  chk("R3 requalify wait", lock_data, 1'b0);
    cyc(70); chk("R3 relock", lock_data, 1'b1);
  endtask

  task automatic t_level;
    lvl_ok = 1'b0;
    cyc(5); chk("R4 level drop", lock_data, 1'b0);
    lvl_ok = 1'b1;
    cyc(75); chk("R4 relock", lock_data, 1'b1);
  endtask

  task automatic t_detoff;
    det_en = 1'b0; lvl_ok = 1'b0; hold = 1'b1;
    cyc(100); chk("R6 ignored", lock_data, 1'b1);
    hold = 1'b0; lvl_ok = 1'b1;
    rng_ok = 1'b0;
    cyc(5); chk("R5 range drop", lock_data, 1'b0);
    rng_ok = 1'b1; det_en = 1'b1;
    cyc(75); chk("R5 relock", lock_data, 1'b1);
  endtask

  task automatic t_force;
    @(posedge clk); #2;
    use_data = 1'b0; #1;
    chk("R7 lock", lock_data, 1'b0); chk("R7 fault", link_fault_n, 1'b0);
    cyc(20); chk("R7 held", lock_data, 1'b0);
    use_data = 1'b1;
    cyc(40); chk("R8 restart", lock_data, 1'b0);
    cyc(35); chk("R8 relock", lock_data, 1'b1);
  endtask

  task automatic t_sync;
    rng_ok = 1'b0;
    #1; chk("R10 not yet", lock_data, 1'b1);
    cyc(1); chk("R10 one stage", lock_data, 1'b1);
    cyc(4); chk("R10 through", lock_data, 1'b0);
    rng_ok = 1'b1;
  endtask

  initial begin
    t_reset; t_qualify; t_density; t_level; t_detoff; t_force; t_sync;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule